// File: doc/BRIEF.md
# Duty Cycle Divider with Iterative Reciprocal

This block produces the next pulse-width code for a digitally controlled step-down regulator. It adds a commanded output-voltage code and a signed, already filtered error code, then divides the sum by the measured input-voltage code. The divisor is the live measurement of the input supply, not a fixed constant, so the computed duty cycle follows changes in the supply. The quotient is scaled to a pulse-width code in which full scale stands for a duty of one.

The division takes several cycles. The input-voltage code is normalised into the range [0.5, 1). A small constant table, indexed by the bits just below the leading one, gives a starting guess for the reciprocal. A fixed number of Newton-Raphson refinements, x' = x*(2 - m*x), then improve that guess. The refined reciprocal is multiplied by the sum and shifted back by the normalisation amount. A controller pulses `start` with the three codes present. The block captures them and later pulses `done` together with the new code. A change in the input voltage therefore reaches the output only on the next computation.

Top module: `duty_recip_core`

## Requirements
- R1: While `rst` is high and after it is released, `pw_code`, `done` and `vin_zero_err` read 0 until the first result.
- R2: `cmd_code` (unsigned), `err_code` (two's complement) and `vin_code` (unsigned) share one LSB weight. For a positive sum S = cmd_code + err_code and a nonzero vin_code, `pw_code` is within 1 of min(floor(S*2^PW_W / vin_code), 2^PW_W - 1).
- R3: When S is zero or negative, `pw_code` is exactly 0.
- R4: When S*2^PW_W / vin_code is at or above 2^PW_W, `pw_code` is exactly 2^PW_W - 1 (all ones).
- R5: A vin_code of 0 skips the reciprocal and returns `pw_code` = all ones with `vin_zero_err` = 1. Any result with a nonzero vin_code returns `vin_zero_err` = 0.
- R6: If `start` is sampled at clock edge k, `done` and the new result appear after edge k+2*NR_ITERS+2 (edge k+8 by default). For a vin_code of 0 they appear after edge k+1.
- R7: `done` is high for exactly one cycle per result. `pw_code` and `vin_zero_err` hold their values in every cycle in which `done` is low.
- R8: The operand codes are captured at the accepted `start`. A `start` raised while a computation is in progress is ignored, and later changes of the inputs, including vin_code, do not alter that computation's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new computation when idle |
| cmd_code | input | CMD_W | Scaled output-voltage command, unsigned |
| err_code | input | ERR_W | Filtered error, two's complement, same scale as the command |
| vin_code | input | VIN_W | Measured input-voltage code, same scale |
| pw_code | output | PW_W | Pulse-width code, all ones means full duty |
| done | output | 1 | One-cycle result strobe |
| vin_zero_err | output | 1 | Set with a result whose input-voltage code was zero |

## Verification
The hardest situation to reach from the ports is a second request that arrives in the middle of the refinement loop while the operand inputs also change. In that case the reciprocal already in flight must finish from the captured divisor and produce only one strobe. The bench starts a computation, waits a few cycles, and then drives a different command, error and divisor together with a fresh `start` pulse. It then checks that the result matches the first operands, that no second strobe follows, and that a fresh request afterwards gives the second operands' value. The power-of-two divisors, the zero divisor and the clamp at both ends are driven as separate directed cases.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_MT,
    ST_MX,
    ST_FIN
  } dcr_state_e;
endpackage

// File: rtl/dcr_normalize.sv
// Left-justifies the divisor, reports the shift, and picks a reciprocal seed.
module dcr_normalize #(
  parameter int VIN_W  = 10,
  parameter int FRAC_W = 20,
  parameter int SEED_B = 3,
  parameter int X_W    = FRAC_W + 2,
  parameter int S_W    = $clog2(VIN_W)
) (
  input  logic [VIN_W-1:0]  vin,
  output logic [FRAC_W-1:0] m_frac,
  output logic [S_W-1:0]    shamt,
  output logic [X_W-1:0]    seed,
  output logic              is_zero
);
  localparam int TAB_N = 1 << SEED_B;
  localparam logic [63:0] NUM = 64'd1 << (FRAC_W + SEED_B + 2);

  logic [X_W-1:0]    tab [TAB_N];
  logic [S_W-1:0]    lead;
  logic [VIN_W-1:0]  vn;
  logic [SEED_B-1:0] idx;

  // Seed = 1 / midpoint of each interval of the normalised divisor.
  for (genvar g = 0; g < TAB_N; g++) begin : g_seed
    assign tab[g] = X_W'(NUM / 64'(2 * TAB_N + 2 * g + 1));
  end

  always_comb begin
    lead = '0;
    for (int i = 0; i < VIN_W; i++) begin
      if (vin[i]) lead = S_W'(i);
    end
    shamt   = S_W'(VIN_W - 1) - lead;
    vn      = vin << shamt;
    m_frac  = FRAC_W'(vn) << (FRAC_W - VIN_W);
    idx     = vn[VIN_W-2 -: SEED_B];
    seed    = tab[idx];
    is_zero = (vin == '0);
  end
endmodule

// File: rtl/dcr_nr_step.sv
// Datapath for one Newton-Raphson refinement, split over two cycles.
module dcr_nr_step #(
  parameter int FRAC_W = 20,
  parameter int X_W    = FRAC_W + 2
) (
  input  logic [FRAC_W-1:0] m_frac,
  input  logic [X_W-1:0]    x_cur,
  input  logic [X_W-1:0]    t_reg,
  output logic [X_W-1:0]    t_new,
  output logic [X_W-1:0]    x_new
);
  localparam int P1_W = FRAC_W + X_W;
  localparam int P2_W = 2 * X_W;
  localparam logic [X_W-1:0] TWO = X_W'(1) << (FRAC_W + 1);

  logic [P1_W-1:0] p1;
  logic [P2_W-1:0] p2;
  logic [X_W-1:0]  corr;

  always_comb begin
    p1    = P1_W'(m_frac) * P1_W'(x_cur);
    t_new = X_W'(p1 >> FRAC_W);
    corr  = TWO - t_reg;
    p2    = P2_W'(x_cur) * P2_W'(corr);
    x_new = X_W'(p2 >> FRAC_W);
  end
endmodule

// File: rtl/dcr_scale.sv
// Multiplies the sum by the reciprocal, undoes the normalisation, clamps.
module dcr_scale #(
  parameter int SUM_W  = 10,
  parameter int VIN_W  = 10,
  parameter int FRAC_W = 20,
  parameter int PW_W   = 10,
  parameter int X_W    = FRAC_W + 2,
  parameter int S_W    = $clog2(VIN_W)
) (
  input  logic signed [SUM_W-1:0] sum,
  input  logic [X_W-1:0]          recip,
  input  logic [S_W-1:0]          shamt,
  output logic [PW_W-1:0]         pw
);
  localparam int MAG_W = SUM_W - 1;
  localparam int P_W   = MAG_W + X_W + VIN_W;
  localparam int QSH   = FRAC_W + VIN_W - PW_W;
  localparam logic [P_W-1:0] PW_MAX = P_W'((64'd1 << PW_W) - 64'd1);

  logic [MAG_W-1:0] mag;
  logic [P_W-1:0]   prod;
  logic [P_W-1:0]   quo;

  always_comb begin
    mag  = sum[MAG_W-1:0];
    prod = (P_W'(mag) * P_W'(recip)) << shamt;
    quo  = prod >> QSH;
    if (sum <= 0)            pw = '0;
    else if (quo > PW_MAX)   pw = '1;
    else                     pw = PW_W'(quo);
  end
endmodule

// File: rtl/duty_recip_core.sv
module duty_recip_core #(
  parameter int CMD_W    = 8,
  parameter int ERR_W    = 8,
  parameter int VIN_W    = 10,
  parameter int PW_W     = 10,
  parameter int FRAC_W   = 20,
  parameter int SEED_B   = 3,
  parameter int NR_ITERS = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [CMD_W-1:0]        cmd_code,
  input  logic signed [ERR_W-1:0] err_code,
  input  logic [VIN_W-1:0]        vin_code,
  output logic [PW_W-1:0]         pw_code,
  output logic                    done,
  output logic                    vin_zero_err
);
  import dcr_pkg::*;

  localparam int X_W    = FRAC_W + 2;
  localparam int S_W    = $clog2(VIN_W);
  localparam int SUM_W  = CMD_W + 2;
  localparam int ITER_W = $clog2(NR_ITERS + 1);

  dcr_state_e               state;
  logic [CMD_W-1:0]         cmd_q;
  logic signed [ERR_W-1:0]  err_q;
  logic [VIN_W-1:0]         vin_q;
  logic [FRAC_W-1:0]        m_q;
  logic [X_W-1:0]           x_q;
  logic [X_W-1:0]           t_q;
  logic [S_W-1:0]           sh_q;
  logic [ITER_W-1:0]        iter;

  logic [FRAC_W-1:0]        m_c;
  logic [S_W-1:0]           sh_c;
  logic [X_W-1:0]           seed_c;
  logic                     zero_c;
  logic [X_W-1:0]           t_c;
  logic [X_W-1:0]           x_c;
  logic signed [SUM_W-1:0]  sum_c;
  logic [PW_W-1:0]          pw_c;

  assign sum_c = $signed({2'b00, cmd_q}) +
                 $signed({{(SUM_W-ERR_W){err_q[ERR_W-1]}}, err_q});

  dcr_normalize #(
    .VIN_W(VIN_W), .FRAC_W(FRAC_W), .SEED_B(SEED_B), .X_W(X_W), .S_W(S_W)
  ) norm_i (
    .vin(vin_q), .m_frac(m_c), .shamt(sh_c), .seed(seed_c), .is_zero(zero_c)
  );

  dcr_nr_step #(.FRAC_W(FRAC_W), .X_W(X_W)) step_i (
    .m_frac(m_q), .x_cur(x_q), .t_reg(t_q), .t_new(t_c), .x_new(x_c)
  );

  dcr_scale #(
    .SUM_W(SUM_W), .VIN_W(VIN_W), .FRAC_W(FRAC_W), .PW_W(PW_W),
    .X_W(X_W), .S_W(S_W)
  ) scale_i (
    .sum(sum_c), .recip(x_q), .shamt(sh_q), .pw(pw_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      done         <= 1'b0;
      pw_code      <= '0;
      vin_zero_err <= 1'b0;
      cmd_q        <= '0;
      err_q        <= '0;
      vin_q        <= '0;
      m_q          <= '0;
      x_q          <= '0;
      t_q          <= '0;
      sh_q         <= '0;
      iter         <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            cmd_q <= cmd_code;
            err_q <= err_code;
            vin_q <= vin_code;
            state <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (zero_c) begin
            pw_code      <= '1;
            vin_zero_err <= 1'b1;
            done         <= 1'b1;
            state        <= ST_IDLE;
          end else begin
            m_q   <= m_c;
            x_q   <= seed_c;
            sh_q  <= sh_c;
            iter  <= '0;
            state <= ST_MT;
          end
        end
        ST_MT: begin
          t_q   <= t_c;
          state <= ST_MX;
        end
        ST_MX: begin
          x_q  <= x_c;
          iter <= iter + 1'b1;
          if (iter == ITER_W'(NR_ITERS - 1)) state <= ST_FIN;
          else                               state <= ST_MT;
        end
        ST_FIN: begin
          pw_code      <= pw_c;
          vin_zero_err <= 1'b0;
          done         <= 1'b1;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcr_duty_chk.sv
module dcr_duty_chk #(
  parameter int PW_W     = 10,
  parameter int NR_ITERS = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            done,
  input logic [PW_W-1:0] pw_code,
  input logic            vin_zero_err
);
  localparam logic [7:0] LAT = 8'(2 * NR_ITERS + 2);

  logic       busy_ck;
  logic [7:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_ck <= 1'b0;
      cnt     <= '0;
    end else begin
      if (busy_ck && cnt != 8'hFF) cnt <= cnt + 8'd1;
      if (done) busy_ck <= 1'b0;
      if (start && (!busy_ck || done)) begin
        busy_ck <= 1'b1;
        cnt     <= '0;
      end
    end
  end

  // R7: single-cycle strobe
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: result held between strobes
  a_r7_pw_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(pw_code));

  a_r7_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(vin_zero_err));

  // R5: zero divisor gives full scale
  a_r5_zero_full: assert property (@(posedge clk) disable iff (rst)
    (done && vin_zero_err) |-> (pw_code == '1));

  // R6 and R8: strobe only at the fixed distance from an accepted request
  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_ck && (cnt == (vin_zero_err ? 8'd1 : LAT))));
endmodule

bind duty_recip_core dcr_duty_chk #(.PW_W(PW_W), .NR_ITERS(NR_ITERS)) chk_i (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .pw_code(pw_code), .vin_zero_err(vin_zero_err)
);

// File: tb/duty_recip_core_tb_top.sv
module duty_recip_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW_W = 10;
  localparam int PW_MAX = (1 << PW_W) - 1;
  localparam int LAT_N = 9;   // posedges from start sample to done visible
  localparam int LAT_Z = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [7:0]        cmd_code = '0;
  logic signed [7:0] err_code = '0;
  logic [9:0]        vin_code = '0;
  logic [PW_W-1:0]   pw_code;
  logic              done;
  logic              vin_zero_err;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  duty_recip_core dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd_code(cmd_code),
    .err_code(err_code), .vin_code(vin_code), .pw_code(pw_code),
    .done(done), .vin_zero_err(vin_zero_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_pw(input int c, input int e, input int v);
    int s;
    int q;
    s = c + e;
    if (v == 0) return PW_MAX;
    if (s <= 0) return 0;
    q = (s * (1 << PW_W)) / v;
    return (q > PW_MAX) ? PW_MAX : q;
  endfunction

  // Issue one request, wait for done, report result and latency.
  task automatic run_op(input int c, input int e, input int v,
                        output int pw, output int flag, output int lat);
    @(negedge clk);
    cmd_code = 8'(c); err_code = 8'(e); vin_code = 10'(v); start = 1'b1;
    lat = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (done) break;
    end
    pw = int'(pw_code);
    flag = int'(vin_zero_err);
  endtask

  task automatic op_near(input int c, input int e, input int v, input string tag);
    int pw, fl, lat, ex, d;
    run_op(c, e, v, pw, fl, lat);
    ex = ref_pw(c, e, v);
    d = pw - ex;
    check(d >= -1 && d <= 1, {tag, " R2 quotient"}, pw, ex);
    check(lat == LAT_N, {tag, " R6 latency"}, lat, LAT_N);
    check(fl == 0, {tag, " R5 flag clear"}, fl, 0);
  endtask

  task automatic t_reset();
    check(pw_code == 0, "R1 pw after reset", int'(pw_code), 0);
    check(done == 0, "R1 done after reset", int'(done), 0);
    check(vin_zero_err == 0, "R1 flag after reset", int'(vin_zero_err), 0);
  endtask

  task automatic t_quotient();
    op_near(100, 0, 1000, "q1");
    op_near(80, -20, 600, "q2");
    op_near(128, 0, 512, "q3 pow2");
    op_near(255, 127, 1023, "q4 max codes");
    op_near(1, 0, 7, "q5 small");
    op_near(90, 37, 700, "q6 pos err");
    for (int v = 190; v < 1024; v += 97) op_near(187, 0, v, "sweep");
  endtask

  task automatic t_negative();
    int pw, fl, lat;
    run_op(10, -40, 500, pw, fl, lat);
    check(pw == 0, "R3 negative sum", pw, 0);
    run_op(20, -20, 500, pw, fl, lat);
    check(pw == 0, "R3 zero sum", pw, 0);
    run_op(0, -128, 1, pw, fl, lat);
    check(pw == 0, "R3 most negative", pw, 0);
  endtask

  task automatic t_high();
    int pw, fl, lat;
    run_op(50, 30, 3, pw, fl, lat);
    check(pw == PW_MAX, "R4 clamp high", pw, PW_MAX);
    run_op(200, 0, 200, pw, fl, lat);
    check(pw == PW_MAX, "R4 unity ratio", pw, PW_MAX);
    run_op(255, 127, 1, pw, fl, lat);
    check(pw == PW_MAX, "R4 divisor one", pw, PW_MAX);
  endtask

  task automatic t_zero_vin();
    int pw, fl, lat;
    run_op(100, 0, 0, pw, fl, lat);
    check(pw == PW_MAX, "R5 zero vin width", pw, PW_MAX);
    check(fl == 1, "R5 zero vin flag", fl, 1);
    check(lat == LAT_Z, "R6 zero vin latency", lat, LAT_Z);
    run_op(10, -40, 0, pw, fl, lat);
    check(pw == PW_MAX && fl == 1, "R5 zero vin negative sum", pw, PW_MAX);
    run_op(100, 0, 1000, pw, fl, lat);
    check(fl == 0, "R5 flag cleared", fl, 0);
  endtask

  task automatic t_hold();
    int pw, fl, lat;
    int held;
    run_op(60, 4, 256, pw, fl, lat);
    held = pw;
    for (int i = 0; i < 6; i++) begin
      cmd_code = 8'(i * 31); err_code = 8'(-i); vin_code = 10'(i);
      @(posedge clk);
      @(negedge clk);
      check(done == 0, "R7 done single cycle", int'(done), 0);
      check(int'(pw_code) == held, "R7 pw held", int'(pw_code), held);
    end
  endtask

  task automatic t_busy();
    int pw, ex, dones;
    @(negedge clk);
    cmd_code = 8'd120; err_code = -8'sd10; vin_code = 10'd880; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    cmd_code = 8'd5; err_code = 8'sd0; vin_code = 10'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    vin_code = 10'd3;
    dones = 0;
    pw = -1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) begin
        dones++;
        pw = int'(pw_code);
      end
    end
    ex = ref_pw(120, -10, 880);
    check(dones == 1, "R8 one result only", dones, 1);
    check(pw >= ex - 1 && pw <= ex + 1, "R8 captured operands", pw, ex);
    check(vin_zero_err == 0, "R8 ignored zero vin", int'(vin_zero_err), 0);
    op_near(5, 0, 3, "R8 next request");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_quotient();
    t_negative();
    t_high();
    t_zero_vin();
    t_hold();
    t_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule